// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block owns the internal reset of a small processor core. It asserts reset on a power-on pulse, on a qualified supply-low (brown-out) condition, on a low level at the external clear pin and on a watchdog request. It then holds reset until the configured start-up delays have run. The delay chain has two stages. A power-up delay runs first. An oscillator settling delay follows it, but only when the clock source is a crystal. Both stages are timed from the power-on or brown-out release and never wait for the external clear pin. A board can therefore hold the pin low past the delays and start the core on the edge where the pin is released.

The block also keeps two sticky status flags that software reads and writes. One records a power-on event and the other records a brown-out. Software sets both flags after start-up. On a later reset it reads them to tell which kind of event occurred. Every delay length is a parameter counted in reference-clock cycles.

Top module: `startup_reset_seq`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `core_rst_o` is 1 and `pwr_flags_o` is 2'b00.
- R2: `por_i` sampled high at any clock edge puts the sequencer back into its hold state, so `core_rst_o` is 1 after that edge whatever the previous state was.
- R3: When `cfg_pwrup_dis_i` is 0, the power-up delay holds reset for exactly `PWRUP_CYC` cycles. The count starts at the first edge where the hold condition is sampled clear. When `cfg_pwrup_dis_i` is 1, no power-up delay is inserted.
- R4: The oscillator delay of `OSC_CYC` cycles follows the power-up delay for clock modes 2'b00 (low-power crystal) and 2'b01 (crystal). It is skipped for modes 2'b10 (internal RC) and 2'b11 (external clock).
- R5: With clock mode 2'b11, the power-up delay disabled and `ext_clr_n_i` high, `core_rst_o` falls at the first edge that samples the hold condition clear.
- R6: With `cfg_bo_en_i` = 1, `supply_low_i` sampled high on `BO_QUAL_CYC` consecutive edges forces reset at the last of those edges. A shorter low pulse has no effect, and so does any low pulse while `cfg_bo_en_i` = 0.
- R7: After a brown-out, reset stays asserted while `supply_low_i` is high. Once the supply recovers, the same delay chain as for power-on runs before release, and the power-up stage is included only if it is enabled.
- R8: A brown-out that trips during the power-up delay returns the sequencer to hold and discards the partial count. After recovery, a full `PWRUP_CYC` count runs again.
- R9: The delays run while `ext_clr_n_i` is low. With all delays done, `core_rst_o` falls at the edge that samples the pin high. While running, the pin sampled low asserts `core_rst_o` at that edge.
- R10: `wdt_rst_i` sampled high asserts `core_rst_o` at that edge. The core restarts at the next edge that samples the request low with `ext_clr_n_i` high, and no delay is inserted.
- R11: In `pwr_flags_o`, bit 1 is the power-on flag and bit 0 is the brown-out flag. A write loads both bits from `sw_wdata_i`. `por_i` clears bit 1 and a brown-out trip clears bit 0, and each of these clears wins over a write in the same cycle. Watchdog and pin resets leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| por_i | input | 1 | Power-on pulse, active high |
| supply_low_i | input | 1 | Supply-below-threshold comparator flag |
| ext_clr_n_i | input | 1 | External clear pin, active low |
| wdt_rst_i | input | 1 | Watchdog reset request |
| cfg_bo_en_i | input | 1 | Brown-out detection enable |
| cfg_pwrup_dis_i | input | 1 | Power-up delay disable (0 = delay active) |
| cfg_clk_mode_i | input | 2 | Clock mode: 00 LP crystal, 01 crystal, 10 internal RC, 11 external |
| sw_wr_i | input | 1 | Status register write strobe |
| sw_wdata_i | input | 2 | Status register write data |
| pwr_flags_o | output | 2 | Status flags: bit 1 power-on, bit 0 brown-out |
| core_rst_o | output | 1 | Internal core reset, active high |

## Verification
Call E1 the first edge that samples the hold condition clear, and D the sum of the enabled delay lengths. `core_rst_o` is then due D edges after E1. The bench counts rising edges from the release and expects `core_rst_o` low after exactly D+1 of them, and still high one edge earlier. Brown-out trips are due on the `BO_QUAL_CYC`-th consecutive low sample, and pin, watchdog and status effects are due one edge after their input. The bench changes every input on a falling edge and reads every output on the next falling edge, so each sample falls half a cycle after the edge that produced it.

// File: rtl/startup_reset_pkg.sv
package startup_reset_pkg;

  typedef enum logic [2:0] {
    ST_HOLD       = 3'd0,
    ST_PWRUP_WAIT = 3'd1,
    ST_OSC_WAIT   = 3'd2,
    ST_PIN_WAIT   = 3'd3,
    ST_RUN        = 3'd4
  } seq_state_e;

  // clock mode codes; bit 1 set means no oscillator settling delay
  localparam logic [1:0] CLK_LP_XTAL = 2'b00;
  localparam logic [1:0] CLK_XTAL    = 2'b01;
  localparam logic [1:0] CLK_INT_RC  = 2'b10;
  localparam logic [1:0] CLK_EXT     = 2'b11;

endpackage

// File: rtl/startup_delay_cnt.sv
module startup_delay_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!done_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: a running count advances by one every cycle until it completes
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$past(done_o)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/supply_low_qual.sv
module supply_low_qual #(
  parameter int unsigned QUAL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic low_i,
  output logic trip_o
);

  localparam int unsigned W = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(QUAL_CYC - 1);

  logic [W-1:0] run_q, run_d;
  logic         run_en;
  logic         low_seen;

  assign low_seen = en_i && low_i;
  assign trip_o   = low_seen && (run_q == LAST);

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (!low_seen) begin
      run_en = (run_q != '0);
      run_d  = '0;
    end else if (run_q != LAST) begin
      run_en = 1'b1;
      run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  generate
    if (QUAL_CYC > 1) begin : g_qual_chk
      // R6: a trip is always preceded by a qualified low sample
      assert_trip_needs_history_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(en_i && low_i));
    end
  endgenerate

endmodule

// File: rtl/pwr_flag_reg.sv
module pwr_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       bo_trip_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] flags_o
);

  logic [1:0] flags_q, flags_d;
  logic       flags_en;

  assign flags_en = wr_i || por_i || bo_trip_i;

  always_comb begin
    flags_d = flags_q;
    if (wr_i)      flags_d = wdata_i;
    if (por_i)     flags_d[1] = 1'b0;
    if (bo_trip_i) flags_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= 2'b00;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R11: a power-on pulse always leaves the power-on flag cleared
  assert_por_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> !flags_q[1]);

  // R11: a brown-out trip always leaves the brown-out flag cleared
  assert_bo_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bo_trip_i |=> !flags_q[0]);

endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
  import startup_reset_pkg::*;
#(
  parameter int unsigned PWRUP_CYC   = 9_000_000,
  parameter int unsigned OSC_CYC     = 1024,
  parameter int unsigned BO_QUAL_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       supply_low_i,
  input  logic       ext_clr_n_i,
  input  logic       wdt_rst_i,
  input  logic       cfg_bo_en_i,
  input  logic       cfg_pwrup_dis_i,
  input  logic [1:0] cfg_clk_mode_i,
  input  logic       sw_wr_i,
  input  logic [1:0] sw_wdata_i,
  output logic [1:0] pwr_flags_o,
  output logic       core_rst_o
);

  seq_state_e st_q, st_d;
  logic       bo_trip;
  logic       pwrup_done, osc_done;
  logic       osc_needed, hold_clear, pin_ok;
  seq_state_e after_osc, after_pwrup, after_hold;

  supply_low_qual #(.QUAL_CYC(BO_QUAL_CYC)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cfg_bo_en_i),
    .low_i  (supply_low_i),
    .trip_o (bo_trip)
  );

  startup_delay_cnt #(.LIMIT(PWRUP_CYC)) u_pwrup_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == ST_PWRUP_WAIT),
    .done_o (pwrup_done)
  );

  startup_delay_cnt #(.LIMIT(OSC_CYC)) u_osc_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == ST_OSC_WAIT),
    .done_o (osc_done)
  );

  pwr_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_i     (por_i),
    .bo_trip_i (bo_trip),
    .wr_i      (sw_wr_i),
    .wdata_i   (sw_wdata_i),
    .flags_o   (pwr_flags_o)
  );

  assign osc_needed  = !cfg_clk_mode_i[1];
  assign hold_clear  = !por_i && !(cfg_bo_en_i && supply_low_i);
  assign pin_ok      = ext_clr_n_i && !wdt_rst_i;
  assign after_osc   = pin_ok ? ST_RUN : ST_PIN_WAIT;
  assign after_pwrup = osc_needed ? ST_OSC_WAIT : after_osc;
  assign after_hold  = !cfg_pwrup_dis_i ? ST_PWRUP_WAIT : after_pwrup;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:       if (hold_clear) st_d = after_hold;
      ST_PWRUP_WAIT: if (pwrup_done) st_d = after_pwrup;
      ST_OSC_WAIT:   if (osc_done)   st_d = after_osc;
      ST_PIN_WAIT:   if (pin_ok)     st_d = ST_RUN;
      ST_RUN:        if (!pin_ok)    st_d = ST_PIN_WAIT;
      default:                       st_d = ST_HOLD;
    endcase
    if (por_i || bo_trip) st_d = ST_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign core_rst_o = (st_q != ST_RUN);

  // R2: a power-on pulse always yields reset on the following cycle
  assert_por_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> core_rst_o);

  // R6: a qualified brown-out lands the sequencer in hold
  assert_bo_to_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bo_trip |=> (st_q == ST_HOLD));

  // R4: the oscillator delay only runs for crystal modes
  assert_osc_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OSC_WAIT) |-> !cfg_clk_mode_i[1]);

  // R9: the core only runs when the clear pin was high at the last edge
  assert_run_pin_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> $past(ext_clr_n_i));

endmodule

// File: tb/startup_reset_seq_tb.sv
module startup_reset_seq_tb;

  localparam int P = 10;
  localparam int O = 6;
  localparam int Q = 3;

  logic       clk = 1'b0;
  logic       rst_n, por_i, supply_low_i, ext_clr_n_i, wdt_rst_i;
  logic       cfg_bo_en_i, cfg_pwrup_dis_i, sw_wr_i;
  logic [1:0] cfg_clk_mode_i, sw_wdata_i, pwr_flags_o;
  logic       core_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  startup_reset_seq #(.PWRUP_CYC(P), .OSC_CYC(O), .BO_QUAL_CYC(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .supply_low_i(supply_low_i),
    .ext_clr_n_i(ext_clr_n_i), .wdt_rst_i(wdt_rst_i), .cfg_bo_en_i(cfg_bo_en_i),
    .cfg_pwrup_dis_i(cfg_pwrup_dis_i), .cfg_clk_mode_i(cfg_clk_mode_i),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .pwr_flags_o(pwr_flags_o),
    .core_rst_o(core_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // edges counted from now until core_rst_o is seen low
  task automatic measure(output int edges);
    edges = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (!core_rst_o) break;
    end
  endtask

  function automatic int delay_len(input bit dis, input logic [1:0] mode);
    return (dis ? 0 : P) + (mode[1] ? 0 : O);
  endfunction

  task automatic por_pulse();
    por_i = 1'b1;
    tick(1);
    chk(core_rst_o == 1'b1, "R2", int'(core_rst_o), 1);
    tick(2);
    por_i = 1'b0;
  endtask

  task automatic write_flags(input logic [1:0] v);
    sw_wr_i = 1'b1;
    sw_wdata_i = v;
    tick(1);
    sw_wr_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e;
    rst_n = 1'b0; por_i = 1'b0; supply_low_i = 1'b0; ext_clr_n_i = 1'b1;
    wdt_rst_i = 1'b0; cfg_bo_en_i = 1'b0; cfg_pwrup_dis_i = 1'b0;
    cfg_clk_mode_i = 2'b00; sw_wr_i = 1'b0; sw_wdata_i = 2'b00;
    tick(3);
    chk(core_rst_o == 1'b1, "R1 reset", int'(core_rst_o), 1);
    chk(pwr_flags_o == 2'b00, "R1 flags", int'(pwr_flags_o), 0);
    rst_n = 1'b1;
    tick(1);
    chk(core_rst_o == 1'b1, "R1 after release", int'(core_rst_o), 1);

    // R3 R4 R5: power-on delay chain over every configuration
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin
        cfg_pwrup_dis_i = d[0];
        cfg_clk_mode_i = m[1:0];
        por_pulse();
        chk(pwr_flags_o[1] == 1'b0, "R11 por flag", int'(pwr_flags_o[1]), 0);
        measure(e);
        chk(e == delay_len(d[0], m[1:0]) + 1, (d == 1 && m == 3) ? "R5" : "R3/R4",
            e, delay_len(d[0], m[1:0]) + 1);
      end
    end

    write_flags(2'b11);
    chk(pwr_flags_o == 2'b11, "R11 write", int'(pwr_flags_o), 3);

    // R6: short pulse with detection on, long pulse with detection off
    cfg_bo_en_i = 1'b1;
    supply_low_i = 1'b1;
    tick(Q - 1);
    supply_low_i = 1'b0;
    tick(3);
    chk(core_rst_o == 1'b0, "R6 short pulse", int'(core_rst_o), 0);
    chk(pwr_flags_o == 2'b11, "R6 short pulse flags", int'(pwr_flags_o), 3);
    cfg_bo_en_i = 1'b0;
    supply_low_i = 1'b1;
    tick(Q + 3);
    supply_low_i = 1'b0;
    tick(1);
    chk(core_rst_o == 1'b0, "R6 disabled", int'(core_rst_o), 0);

    // R6 R7 R11: brown-out trip and recovery over every configuration
    cfg_bo_en_i = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin
        cfg_pwrup_dis_i = d[0];
        cfg_clk_mode_i = m[1:0];
        write_flags(2'b11);
        supply_low_i = 1'b1;
        tick(Q);
        chk(core_rst_o == 1'b1, "R6 trip", int'(core_rst_o), 1);
        chk(pwr_flags_o == 2'b10, "R11 bo flag", int'(pwr_flags_o), 2);
        tick(5);
        chk(core_rst_o == 1'b1, "R7 held low", int'(core_rst_o), 1);
        supply_low_i = 1'b0;
        measure(e);
        chk(e == delay_len(d[0], m[1:0]) + 1, "R7 recovery", e, delay_len(d[0], m[1:0]) + 1);
      end
    end

    // R8: brown-out during the power-up delay restarts it
    cfg_pwrup_dis_i = 1'b0;
    cfg_clk_mode_i = 2'b11;
    por_pulse();
    tick(5);
    supply_low_i = 1'b1;
    tick(Q);
    chk(core_rst_o == 1'b1, "R8 trip", int'(core_rst_o), 1);
    supply_low_i = 1'b0;
    measure(e);
    chk(e == P + 1, "R8 full restart", e, P + 1);

    // R9: delays run under a held clear pin
    cfg_clk_mode_i = 2'b00;
    ext_clr_n_i = 1'b0;
    por_pulse();
    tick(P + O + 5);
    chk(core_rst_o == 1'b1, "R9 pin held", int'(core_rst_o), 1);
    ext_clr_n_i = 1'b1;
    tick(1);
    chk(core_rst_o == 1'b0, "R9 pin release", int'(core_rst_o), 0);
    ext_clr_n_i = 1'b0;
    tick(1);
    chk(core_rst_o == 1'b1, "R9 pin low in run", int'(core_rst_o), 1);
    ext_clr_n_i = 1'b1;
    tick(1);
    chk(core_rst_o == 1'b0, "R9 pin high again", int'(core_rst_o), 0);

    // R10 R11: watchdog reset, flags untouched
    write_flags(2'b11);
    wdt_rst_i = 1'b1;
    tick(1);
    wdt_rst_i = 1'b0;
    chk(core_rst_o == 1'b1, "R10 wdt asserts", int'(core_rst_o), 1);
    tick(1);
    chk(core_rst_o == 1'b0, "R10 wdt restart", int'(core_rst_o), 0);
    chk(pwr_flags_o == 2'b11, "R11 wdt keeps flags", int'(pwr_flags_o), 3);

    // R11: power-on clear wins over a simultaneous write
    por_i = 1'b1;
    sw_wr_i = 1'b1;
    sw_wdata_i = 2'b11;
    tick(1);
    sw_wr_i = 1'b0;
    por_i = 1'b0;
    chk(pwr_flags_o == 2'b01, "R11 clear precedence", int'(pwr_flags_o), 1);
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule